// File: doc/BRIEF.md
# Strobed Accumulating Adder

This block is a small accumulator datapath built around one shared parallel adder. An operand register captures a value from the operand bus, and an accumulator register takes the adder's output. The adder always forms the sum of the two registers, with no carry-in. Software or a sequencer adds a series of operands in a fixed pattern: clear the accumulator, load an operand, transfer the sum, then load the next operand and transfer again.

Three plain control strobes run the block. Each strobe is sampled on the rising clock edge, which gives clock-enabled captures. The clear strobe is active low and zeroes the accumulator. The load strobe captures the bus into the operand register. The transfer strobe writes the adder sum into the accumulator. The operand bus has no handshake and applies no back-pressure. A strobe held high for one cycle acts exactly once, and the block is always ready to accept it. The accumulator value, the adder sum and the adder carry-out are outputs. The carry is never stored.

Top module: `acc_load_xfer_top`

## Requirements
- R1: `sum_s` always equals (`acc_a` + operand register) modulo 2^W, with the carry-in fixed at 0. `carry_out` is bit W of that sum. Both outputs are combinational.
- R2: With `clr_n` low at a rising edge, `acc_a` becomes 0 after that edge. Clear wins over `transfer`.
- R3: With `load` high at a rising edge, the operand register holds the value `opnd_in` had before that edge.
- R4: With `transfer` high and `clr_n` high at a rising edge, `acc_a` takes the value `sum_s` had before that edge. A sum above 2^W-1 wraps.
- R5: When `load` and `transfer` are both high at the same edge, both registers update from values sampled before that edge. The accumulator receives the old A plus the old operand, and the operand register receives the bus.
- R6: With `load` low, the operand register holds its value. With `transfer` low and `clr_n` high, `acc_a` holds its value.
- R7: While `rst_n` is low, both registers are held at 0.
- R8: The sequence clear, load 1001, transfer, load 0101, transfer leaves `acc_a` at 1001 after the first transfer and at 1110 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all captures on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of both registers |
| clr_n | input | 1 | Active-low clear of the accumulator |
| load | input | 1 | Capture `opnd_in` into the operand register |
| transfer | input | 1 | Capture the adder sum into the accumulator |
| opnd_in | input | W (4) | Operand bus |
| acc_a | output | W (4) | Accumulator register |
| sum_s | output | W (4) | Combinational adder sum |
| carry_out | output | 1 | Adder carry-out, not stored |

## Verification
The assertions check several behaviours on every clock cycle. They check that the sum and carry agree with the arithmetic sum of the two registers. They check the effect of each strobe at the next edge, including clear winning over transfer. They also check that each register holds its value when its strobe is idle. Only the bench scenarios can show how strobes combine over a sequence. Examples are the two-operand accumulation ending at 1110, wrap-around after repeated transfers, and a same-edge load with transfer that uses the old operand.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned ACC_W = 4;

  typedef struct packed {
    logic clr;
    logic load;
    logic xfer;
  } acc_ctl_t;
endpackage

// File: rtl/acc_operand_reg.sv
module acc_operand_reg #(
  parameter int unsigned W = acc_pkg::ACC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q_out <= '0;
    else if (load)
      q_out <= d_in;
  end
endmodule

// File: rtl/acc_ripple_adder.sv
module acc_ripple_adder #(
  parameter int unsigned W = acc_pkg::ACC_W
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] s_out,
  output logic         c_out
);
  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p, g;
    assign p          = a_in[i] ^ b_in[i];
    assign g          = a_in[i] & b_in[i];
    assign s_out[i]   = p ^ carry[i];
    assign carry[i+1] = g | (p & carry[i]);
  end

  assign c_out = carry[W];
endmodule

// File: rtl/acc_sum_reg.sv
module acc_sum_reg #(
  parameter int unsigned W = acc_pkg::ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_pkg::acc_ctl_t ctl,
  input  logic [W-1:0]      sum_in,
  output logic [W-1:0]      q_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q_out <= '0;
    else if (ctl.clr)
      q_out <= '0;
    else if (ctl.xfer)
      q_out <= sum_in;
  end
endmodule

// File: rtl/acc_load_xfer_top.sv
module acc_load_xfer_top #(
  parameter int unsigned W = acc_pkg::ACC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         load,
  input  logic         transfer,
  input  logic [W-1:0] opnd_in,
  output logic [W-1:0] acc_a,
  output logic [W-1:0] sum_s,
  output logic         carry_out
);
  acc_pkg::acc_ctl_t ctl;
  logic [W-1:0]      opnd_q;

  assign ctl.clr  = ~clr_n;
  assign ctl.load = load;
  assign ctl.xfer = transfer;

  acc_operand_reg #(.W(W)) u_opnd (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ctl.load),
    .d_in (opnd_in),
    .q_out(opnd_q)
  );

  acc_ripple_adder #(.W(W)) u_add (
    .a_in (acc_a),
    .b_in (opnd_q),
    .s_out(sum_s),
    .c_out(carry_out)
  );

  acc_sum_reg #(.W(W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .sum_in(sum_s),
    .q_out (acc_a)
  );
endmodule

// File: rtl/acc_load_xfer_chk.sv
module acc_load_xfer_chk #(
  parameter int unsigned W = acc_pkg::ACC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_n,
  input logic         load,
  input logic         transfer,
  input logic [W-1:0] opnd_in,
  input logic [W-1:0] acc_a,
  input logic [W-1:0] sum_s,
  input logic         carry_out,
  input logic [W-1:0] opnd_q
);
  // R1
  always_comb begin
    if (rst_n)
      adder_sum_chk: assert ({carry_out, sum_s} == ({1'b0, acc_a} + {1'b0, opnd_q}));
  end

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> acc_a == '0);

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> opnd_q == $past(opnd_in));

  // R4
  xfer_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (transfer && clr_n) |=> acc_a == $past(sum_s));

  // R5
  both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (transfer && clr_n && load) |=> (acc_a == $past(acc_a + opnd_q)) && (opnd_q == $past(opnd_in)));

  // R6
  opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(opnd_q));

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !transfer) |=> $stable(acc_a));

  // R7
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (acc_a == '0) && (opnd_q == '0));
endmodule

bind acc_load_xfer_top acc_load_xfer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .load     (load),
  .transfer (transfer),
  .opnd_in  (opnd_in),
  .acc_a    (acc_a),
  .sum_s    (sum_s),
  .carry_out(carry_out),
  .opnd_q   (opnd_q)
);

// File: tb/test_acc_load_xfer_top.sv
module test_acc_load_xfer_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr_n = 1'b1;
  logic         load = 1'b0;
  logic         transfer = 1'b0;
  logic [W-1:0] opnd_in = '0;
  logic [W-1:0] acc_a, sum_s;
  logic         carry_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W:0] m_a, m_b;
  logic [2*W:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  acc_load_xfer_top #(.W(W)) i_acc_load_xfer_top (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load(load),
    .transfer(transfer), .opnd_in(opnd_in),
    .acc_a(acc_a), .sum_s(sum_s), .carry_out(carry_out)
  );

  task automatic check(string tag, logic [2*W:0] act, logic [2*W:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {carry,sum,a} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic ld, input logic xf,
                      input logic [W-1:0] op, input string tag);
    logic [W:0] na, nb, s;
    @(negedge clk);
    clr_n = c; load = ld; transfer = xf; opnd_in = op;
    na = !c ? '0 : (xf ? ((m_a + m_b) & 5'h0f) : m_a);
    nb = ld ? {1'b0, op} : m_b;
    s  = na + nb;
    m_a = na; m_b = nb;
    exp_q.push_back({s[W], s[W-1:0], na[W-1:0]});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0)
        check(tag_q.pop_front(), {carry_out, sum_s, acc_a}, exp_q.pop_front());
    end
  end

  initial begin : driver
    m_a = '0; m_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset state", {carry_out, sum_s, acc_a}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 4'h0, "R2 clear");
    step(1, 1, 0, 4'b1001, "R3 load 1001");
    step(1, 0, 1, 4'h0, "R8 first transfer gives 1001");
    step(1, 1, 0, 4'b0101, "R3 load 0101");
    step(1, 0, 1, 4'h0, "R8 second transfer gives 1110");
    step(1, 0, 0, 4'hA, "R6 idle hold");
    step(1, 0, 1, 4'h0, "R4 transfer wraps");
    step(1, 1, 0, 4'hF, "R1 carry out set");
    step(1, 0, 1, 4'h0, "R4 transfer after carry");
    step(1, 1, 1, 4'h7, "R5 load with transfer");
    step(0, 0, 1, 4'h0, "R2 clear beats transfer");
    step(1, 1, 1, 4'h3, "R5 load with transfer from zero");
    step(1, 0, 0, 4'h9, "R6 hold both");
    step(1, 1, 0, 4'hC, "R1 sum after load");
    step(1, 0, 0, 4'h0, "R6 final hold");
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #20000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule